// File: doc/BRIEF.md
# NVMe Controller Register File with Host-Write Log

This block holds the controller register space of an NVMe device and is reached from two sides. The host side reaches it through a plain memory-mapped slave port. The firmware processor reaches it through a second port of the same kind. Both ports can read and write the controller registers and the submission/completion doorbell pairs. Apart from the doorbells and the three extension registers, every register is plain 32-bit storage.

The firmware has to see every host access that needs action. To make this possible, the block keeps the byte address of each host write in a small FIFO. While that FIFO holds an entry, the firmware interrupt line stays high. Firmware reads a status word to see whether entries are waiting, and it reads a data word to take the oldest logged address. Firmware raises message-signalled host interrupts by writing a bitmask to a self-clearing register. Each set bit becomes a one-cycle request on the matching vector.

Both read ports are registered: read data appears one clock after the read strobe. Writes take effect at the clock edge where the write strobe is sampled.

Top module: `nvme_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. The one exception is the version word at byte offset 0x08, which reads the constant 0x0001_0400. After reset, `fw_irq` and every bit of `msi_req` are 0.
- R2: The sixteen controller words at 0x00–0x3C and the doorbell words can be written by either port and read back from either port. A read returns the word in the clock after the read strobe. If both ports write the same word in one cycle, the host value is kept.
- R3: Doorbell pair i (0..4) has its submission tail at 0x1000 + 8·i and its completion head at 0x1000 + 8·i + 4. Each doorbell is an independent 32-bit word.
- R4: Every host write pushes its full 13-bit byte address into the log FIFO, including writes to unmapped or extension offsets. Reads of unmapped offsets return 0.
- R5: A firmware read of the status word at 0x1028 returns the FIFO non-empty flag in bit 0 and a sticky overflow flag in bit 1, with all other bits 0. A firmware write to 0x1028 with bit 1 set clears the overflow flag.
- R6: A firmware read of the data word at 0x102C returns the oldest logged address, zero-extended, and removes it. If the FIFO is empty, the read returns 0 and the FIFO is left unchanged.
- R7: `fw_irq` is high exactly while the FIFO holds at least one entry.
- R8: A firmware write to 0x1030 drives `msi_req[n]` high for exactly the next cycle for every bit n set in the written value. `msi_req` is 0 in every other cycle, and reading 0x1030 returns 0.
- R9: The FIFO holds 16 entries. A host write that arrives while it is full still updates its register, but its address is dropped and the overflow flag is set. This holds even if a pop happens in the same cycle.
- R10: A host write and a firmware pop in the same cycle on a non-full, non-empty FIFO both take effect, and the entry count does not change.
- R11: Host reads of the three extension offsets return 0, and host writes to them change no extension state (`msi_req` stays 0). These writes are still logged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | 13 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid one cycle after h_rd_en |
| f_wr_en | input | 1 | Firmware write strobe |
| f_rd_en | input | 1 | Firmware read strobe |
| f_addr | input | 13 | Firmware byte address |
| f_wdata | input | 32 | Firmware write data |
| f_rdata | output | 32 | Firmware read data, valid one cycle after f_rd_en |
| fw_irq | output | 1 | Level interrupt to firmware, high while the log is non-empty |
| msi_req | output | 32 | One-cycle host interrupt requests, one bit per vector |

## Verification
Some behaviour can be checked one cycle at a time, and the assertions cover it on every cycle. A logged host write always leaves the firmware interrupt raised. The host interrupt bitmask appears for exactly one cycle and nothing appears otherwise. The status bit 0 always matches the interrupt line. An empty-log pop and any host read of an extension offset both return zero. Other behaviour depends on history, so only the bench scenarios can show it: first-in-first-out order of the logged addresses, the drop and sticky overflow after sixteen entries, the host-wins collision, and the doorbell placement.

// File: rtl/nvme_regs_pkg.sv
package nvme_regs_pkg;

   localparam int unsigned WORD_W = 32;

   // firmware read source selector
   typedef enum logic [1:0] {
      FSEL_BANK   = 2'd0,
      FSEL_STATUS = 2'd1,
      FSEL_DATA   = 2'd2,
      FSEL_IRQ    = 2'd3
   } fsel_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/nvme_addr_fifo.sv
module nvme_addr_fifo #(
   parameter int unsigned W     = 13,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         drop
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = PW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  slots [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          full, push_ok, pop_ok;

   assign full    = (count == FULL_CNT);
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign drop    = push && full;
   assign head    = slots[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PW'(push_ok);
         rd_ptr <= rd_ptr + PW'(pop_ok);
         count  <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slots[s] <= '0;
         else if (push_ok && (wr_ptr == PW'(s)))
            slots[s] <= din;
      end
   end

endmodule

// File: rtl/nvme_reg_bank.sv
module nvme_reg_bank #(
   parameter int unsigned WA_W         = 11,
   parameter int unsigned NUM_CTRL     = 16,
   parameter int unsigned NUM_DB_PAIRS = 5,
   parameter int unsigned DB_WORD      = 1024,
   parameter int unsigned VS_IDX       = 2,
   parameter logic [31:0] VS_RST       = 32'h0001_0400
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            h_we,
   input  logic [WA_W-1:0] h_waddr,
   input  logic [31:0]     h_wdata,
   input  logic            f_we,
   input  logic [WA_W-1:0] f_waddr,
   input  logic [31:0]     f_wdata,
   input  logic [WA_W-1:0] h_raddr,
   input  logic [WA_W-1:0] f_raddr,
   output logic [31:0]     h_rword,
   output logic [31:0]     f_rword
);
   localparam int unsigned NUM_WORDS = NUM_CTRL + 2 * NUM_DB_PAIRS;
   localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
   localparam logic [WA_W-1:0] CTRL_END = WA_W'(NUM_CTRL);
   localparam logic [WA_W-1:0] DB_LO    = WA_W'(DB_WORD);
   localparam logic [WA_W-1:0] DB_HI    = WA_W'(DB_WORD + 2 * NUM_DB_PAIRS);

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] idx;
   } slot_t;

   function automatic slot_t map_word(input logic [WA_W-1:0] w);
      slot_t s;
      s.hit = 1'b0;
      s.idx = '0;
      if (w < CTRL_END) begin
         s.hit = 1'b1;
         s.idx = IDX_W'(w);
      end else if ((w >= DB_LO) && (w < DB_HI)) begin
         s.hit = 1'b1;
         s.idx = IDX_W'(w - DB_LO) + IDX_W'(NUM_CTRL);
      end
      return s;
   endfunction

   slot_t hw_s, fw_s, hr_s, fr_s;
   logic [31:0] words [NUM_WORDS];

   assign hw_s = map_word(h_waddr);
   assign fw_s = map_word(f_waddr);
   assign hr_s = map_word(h_raddr);
   assign fr_s = map_word(f_raddr);

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      localparam logic [31:0] RST_VAL = (g == VS_IDX) ? VS_RST : 32'h0;
      logic [31:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= RST_VAL;
         else if (h_we && hw_s.hit && (hw_s.idx == IDX_W'(g)))
            q <= h_wdata;
         else if (f_we && fw_s.hit && (fw_s.idx == IDX_W'(g)))
            q <= f_wdata;
      end
      assign words[g] = q;
   end

   assign h_rword = hr_s.hit ? words[hr_s.idx] : 32'h0;
   assign f_rword = fr_s.hit ? words[fr_s.idx] : 32'h0;

endmodule

// File: rtl/nvme_msi_pulse.sv
module nvme_msi_pulse #(
   parameter int unsigned N_VEC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [N_VEC-1:0] mask,
   output logic [N_VEC-1:0] req
);
   for (genvar v = 0; v < N_VEC; v++) begin : g_vec
      always_ff @(posedge clk) begin
         if (!rst_n)
            req[v] <= 1'b0;
         else
            req[v] <= fire & mask[v];
      end
   end
endmodule

// File: rtl/nvme_ctrl_regs.sv
module nvme_ctrl_regs
   import nvme_regs_pkg::*;
#(
   parameter int unsigned ADDR_W       = 13,
   parameter int unsigned NUM_CTRL     = 16,
   parameter int unsigned NUM_DB_PAIRS = 5,
   parameter int unsigned DB_BASE      = 32'h1000,
   parameter int unsigned FIFO_DEPTH   = 16,
   parameter int unsigned VS_IDX       = 2,
   parameter logic [31:0] VS_RST       = 32'h0001_0400,
   parameter int unsigned N_VEC        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr_en,
   input  logic              h_rd_en,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [31:0]       h_wdata,
   output logic [31:0]       h_rdata,
   input  logic              f_wr_en,
   input  logic              f_rd_en,
   input  logic [ADDR_W-1:0] f_addr,
   input  logic [31:0]       f_wdata,
   output logic [31:0]       f_rdata,
   output logic              fw_irq,
   output logic [N_VEC-1:0]  msi_req
);
   localparam int unsigned WA_W       = ADDR_W - 2;
   localparam int unsigned EXT_BASE   = DB_BASE + 8 * NUM_DB_PAIRS;
   localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(EXT_BASE);
   localparam logic [ADDR_W-1:0] DATA_A   = ADDR_W'(EXT_BASE + 4);
   localparam logic [ADDR_W-1:0] IRQ_A    = ADDR_W'(EXT_BASE + 8);

   // elaboration-time parameter checks
   if (!is_pow2(FIFO_DEPTH) || FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if ((DB_BASE % 4) != 0 || (NUM_CTRL * 4) > DB_BASE) begin : g_bad_db
      $error("doorbell base must be word aligned and above the controller words");
   end
   if ((EXT_BASE + 12) > (1 << ADDR_W) || ADDR_W > 32 || ADDR_W < 3) begin : g_bad_aw
      $error("address width cannot hold the register map");
   end
   if (N_VEC < 1 || N_VEC > 32) begin : g_bad_vec
      $error("N_VEC must lie in 1..32");
   end
   if (VS_IDX >= NUM_CTRL) begin : g_bad_vs
      $error("version word must lie among the controller words");
   end

   // firmware-side extension decode
   fsel_e f_sel;
   always_comb begin
      if (f_addr == STATUS_A)      f_sel = FSEL_STATUS;
      else if (f_addr == DATA_A)   f_sel = FSEL_DATA;
      else if (f_addr == IRQ_A)    f_sel = FSEL_IRQ;
      else                         f_sel = FSEL_BANK;
   end

   // register bank
   logic [31:0] h_rword, f_rword;
   nvme_reg_bank #(
      .WA_W        (WA_W),
      .NUM_CTRL    (NUM_CTRL),
      .NUM_DB_PAIRS(NUM_DB_PAIRS),
      .DB_WORD     (DB_BASE / 4),
      .VS_IDX      (VS_IDX),
      .VS_RST      (VS_RST)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .h_we   (h_wr_en),
      .h_waddr(h_addr[ADDR_W-1:2]),
      .h_wdata(h_wdata),
      .f_we   (f_wr_en),
      .f_waddr(f_addr[ADDR_W-1:2]),
      .f_wdata(f_wdata),
      .h_raddr(h_addr[ADDR_W-1:2]),
      .f_raddr(f_addr[ADDR_W-1:2]),
      .h_rword(h_rword),
      .f_rword(f_rword)
   );

   // host write address log
   logic              pop, log_empty, log_drop;
   logic [ADDR_W-1:0] log_head;
   assign pop = f_rd_en && (f_sel == FSEL_DATA);

   nvme_addr_fifo #(
      .W    (ADDR_W),
      .DEPTH(FIFO_DEPTH)
   ) u_log (
      .clk  (clk),
      .rst_n(rst_n),
      .push (h_wr_en),
      .din  (h_addr),
      .pop  (pop),
      .head (log_head),
      .empty(log_empty),
      .drop (log_drop)
   );

   assign fw_irq = !log_empty;

   // sticky overflow flag; a drop outranks a clear in the same cycle
   logic ovf_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (log_drop)
         ovf_q <= 1'b1;
      else if (f_wr_en && (f_sel == FSEL_STATUS) && f_wdata[1])
         ovf_q <= 1'b0;
   end

   // host interrupt pulses
   nvme_msi_pulse #(
      .N_VEC(N_VEC)
   ) u_msi (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (f_wr_en && (f_sel == FSEL_IRQ)),
      .mask (f_wdata[N_VEC-1:0]),
      .req  (msi_req)
   );

   // registered read ports
   always_ff @(posedge clk) begin
      if (!rst_n)
         h_rdata <= '0;
      else if (h_rd_en)
         h_rdata <= h_rword;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_rdata <= '0;
      end else if (f_rd_en) begin
         unique case (f_sel)
            FSEL_STATUS: f_rdata <= {30'h0, ovf_q, !log_empty};
            FSEL_DATA:   f_rdata <= log_empty ? 32'h0 : 32'(log_head);
            FSEL_IRQ:    f_rdata <= 32'h0;
            default:     f_rdata <= f_rword;
         endcase
      end
   end

endmodule

// File: rtl/nvme_ctrl_regs_chk.sv
module nvme_ctrl_regs_chk #(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned N_VEC    = 32,
   parameter int unsigned EXT_BASE = 32'h1028
) (
   input logic              clk,
   input logic              rst_n,
   input logic              h_wr_en,
   input logic              h_rd_en,
   input logic [ADDR_W-1:0] h_addr,
   input logic [31:0]       h_rdata,
   input logic              f_wr_en,
   input logic              f_rd_en,
   input logic [ADDR_W-1:0] f_addr,
   input logic [31:0]       f_wdata,
   input logic [31:0]       f_rdata,
   input logic              fw_irq,
   input logic [N_VEC-1:0]  msi_req
);
   localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(EXT_BASE);
   localparam logic [ADDR_W-1:0] DT_A = ADDR_W'(EXT_BASE + 4);
   localparam logic [ADDR_W-1:0] IQ_A = ADDR_W'(EXT_BASE + 8);

   logic fw_pop, fw_fire, h_ext_rd;
   assign fw_pop   = f_rd_en && (f_addr == DT_A);
   assign fw_fire  = f_wr_en && (f_addr == IQ_A);
   assign h_ext_rd = h_rd_en && ((h_addr == ST_A) || (h_addr == DT_A) || (h_addr == IQ_A));

   // R7
   irq_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr_en && !fw_pop) |=> fw_irq);

   // R8
   msi_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fw_fire |=> (msi_req == $past(f_wdata[N_VEC-1:0])));

   // R8
   msi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fw_fire |=> (msi_req == '0));

   // R5
   status_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f_rd_en && (f_addr == ST_A)) |=> (f_rdata[0] == $past(fw_irq)) && (f_rdata[31:2] == '0));

   // R6
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_pop && !fw_irq) |=> (f_rdata == '0));

   // R11
   host_ext_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_ext_rd |=> (h_rdata == '0));

endmodule

bind nvme_ctrl_regs nvme_ctrl_regs_chk #(
   .ADDR_W  (ADDR_W),
   .N_VEC   (N_VEC),
   .EXT_BASE(EXT_BASE)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .h_wr_en(h_wr_en),
   .h_rd_en(h_rd_en),
   .h_addr (h_addr),
   .h_rdata(h_rdata),
   .f_wr_en(f_wr_en),
   .f_rd_en(f_rd_en),
   .f_addr (f_addr),
   .f_wdata(f_wdata),
   .f_rdata(f_rdata),
   .fw_irq (fw_irq),
   .msi_req(msi_req)
);

// File: tb/nvme_ctrl_regs_tb.sv
module nvme_ctrl_regs_tb;
   localparam int DEPTH  = 16;
   localparam int NWORDS = 26;
   localparam logic [12:0] A_ST = 13'h1028;
   localparam logic [12:0] A_DT = 13'h102C;
   localparam logic [12:0] A_IQ = 13'h1030;
   localparam logic [12:0] A_UN = 13'h0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_wr_en = 1'b0, h_rd_en = 1'b0, f_wr_en = 1'b0, f_rd_en = 1'b0;
   logic [12:0] h_addr = '0, f_addr = '0;
   logic [31:0] h_wdata = '0, f_wdata = '0;
   logic [31:0] h_rdata, f_rdata, msi_req;
   logic        fw_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] mem_m [NWORDS];
   logic [12:0] q_m [$];
   logic        ovf_m;

   always #5 clk = ~clk;

   nvme_ctrl_regs u_dut (
      .clk(clk), .rst_n(rst_n),
      .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .f_wr_en(f_wr_en), .f_rd_en(f_rd_en), .f_addr(f_addr), .f_wdata(f_wdata), .f_rdata(f_rdata),
      .fw_irq(fw_irq), .msi_req(msi_req)
   );

   function automatic int widx(input logic [12:0] a);
      int w;
      w = int'(a >> 2);
      if (w < 16) return w;
      if (w >= 'h400 && w < 'h40A) return 16 + w - 'h400;
      return -1;
   endfunction

   function automatic logic [31:0] host_view(input logic [12:0] a);
      int i;
      i = widx(a);
      return (i >= 0) ? mem_m[i] : 32'h0;
   endfunction

   function automatic logic [31:0] fw_view(input logic [12:0] a);
      if (a == A_ST) return {30'h0, ovf_m, q_m.size() > 0};
      if (a == A_DT) return (q_m.size() > 0) ? {19'h0, q_m[0]} : 32'h0;
      if (a == A_IQ) return 32'h0;
      return host_view(a);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      foreach (mem_m[i]) mem_m[i] = 32'h0;
      mem_m[2] = 32'h0001_0400;
      q_m.delete();
      ovf_m = 1'b0;
   endtask

   // one clock with both ports driven; model updated; outputs checked
   task automatic op(input string tag,
                     input bit hw, input bit hr, input logic [12:0] ha, input logic [31:0] hd,
                     input bit fw, input bit fr, input logic [12:0] fa, input logic [31:0] fd);
      logic [31:0] exp_h, exp_f, exp_msi;
      int hi, fi, n0;
      @(negedge clk);
      h_wr_en = hw; h_rd_en = hr; h_addr = ha; h_wdata = hd;
      f_wr_en = fw; f_rd_en = fr; f_addr = fa; f_wdata = fd;
      exp_h = host_view(ha);
      exp_f = fw_view(fa);
      exp_msi = (fw && fa == A_IQ) ? fd : 32'h0;
      n0 = q_m.size();
      if (fr && fa == A_DT && n0 > 0) void'(q_m.pop_front());
      if (hw && n0 < DEPTH) q_m.push_back(ha);
      if (hw && n0 >= DEPTH) ovf_m = 1'b1;
      else if (fw && fa == A_ST && fd[1]) ovf_m = 1'b0;
      fi = widx(fa);
      hi = widx(ha);
      if (fw && fi >= 0) mem_m[fi] = fd;
      if (hw && hi >= 0) mem_m[hi] = hd;
      @(posedge clk);
      #1;
      if (hr) check({tag, " host read"}, h_rdata, exp_h);
      if (fr) check({tag, " fw read"}, f_rdata, exp_f);
      check({tag, " msi_req"}, msi_req, exp_msi);
      check({tag, " fw_irq"}, {31'h0, fw_irq}, {31'h0, q_m.size() > 0});
   endtask

   task automatic idle();
      op("idle", 0, 0, '0, '0, 0, 0, '0, '0);
   endtask

   task automatic hwr(input string t, input logic [12:0] a, input logic [31:0] d);
      op(t, 1, 0, a, d, 0, 0, '0, '0);
   endtask

   task automatic frd(input string t, input logic [12:0] a);
      op(t, 0, 0, '0, '0, 0, 1, a, '0);
   endtask

   task automatic hrd(input string t, input logic [12:0] a);
      op(t, 0, 1, a, '0, 0, 0, '0, '0);
   endtask

   task automatic fwr(input string t, input logic [12:0] a, input logic [31:0] d);
      op(t, 0, 0, '0, '0, 1, 0, a, d);
   endtask

   function automatic logic [12:0] pick_addr();
      int r;
      r = int'($urandom_range(0, 9));
      case (r)
         0, 1, 2: return 13'(($urandom_range(0, 15)) * 4);
         3, 4, 5: return 13'('h1000 + ($urandom_range(0, 9)) * 4);
         6: return A_ST;
         7: return A_DT;
         8: return A_IQ;
         default: return A_UN;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1 fw_irq", {31'h0, fw_irq}, 32'h0);
      check("R1 msi_req", msi_req, 32'h0);
      frd("R1 version", 13'h0008);
      hrd("R1 version", 13'h0008);
      for (int i = 0; i < 16; i++) hrd("R1 ctrl", 13'(i * 4));
      for (int i = 0; i < 10; i++) frd("R1 doorbell", 13'('h1000 + i * 4));

      // R3: doorbell layout, R4/R6: logged in order
      for (int i = 0; i < 5; i++) begin
         hwr("R3 sq tail", 13'('h1000 + 8 * i), 32'h5100 + 32'(i));
         hwr("R3 cq head", 13'('h1004 + 8 * i), 32'hC100 + 32'(i));
      end
      for (int i = 0; i < 10; i++) frd("R3 doorbell", 13'('h1000 + i * 4));
      frd("R5 status nonempty", A_ST);
      for (int i = 0; i < 10; i++) frd("R6 pop order", A_DT);
      frd("R6 pop empty", A_DT);
      frd("R5 status empty", A_ST);

      // R4: unmapped writes logged, unmapped reads zero
      hwr("R4 unmapped write", A_UN, 32'hDEAD_BEEF);
      hrd("R4 unmapped read", A_UN);
      frd("R4 unmapped fw read", A_UN);
      frd("R4 logged unmapped", A_DT);

      // R8: host interrupt bitmask
      fwr("R8 vector 31", A_IQ, 32'h8000_0000);
      idle();
      fwr("R8 mask", A_IQ, 32'h0000_8421);
      fwr("R8 back-to-back", A_IQ, 32'hFFFF_FFFF);
      frd("R8 readback", A_IQ);

      // R11: host access to extension offsets
      hwr("R11 host irq write", A_IQ, 32'hFFFF_FFFF);
      hwr("R11 host status write", A_ST, 32'h2);
      hrd("R11 host status read", A_ST);
      hrd("R11 host data read", A_DT);
      frd("R11 logged", A_DT);
      frd("R11 logged", A_DT);

      // R9: overflow, R5: sticky flag and clear
      for (int i = 0; i < DEPTH; i++) hwr("R9 fill", 13'('h1000 + (i % 10) * 4), 32'(i));
      hwr("R9 dropped write", 13'h000C, 32'hA5A5_0003);
      frd("R9 register updated", 13'h000C);
      frd("R5 overflow status", A_ST);
      op("R9 full push with pop", 1, 0, 13'h0010, 32'h77, 0, 1, A_DT, '0);
      op("R10 push with pop", 1, 0, 13'h0014, 32'h88, 0, 1, A_DT, '0);
      for (int i = 0; i < DEPTH - 1; i++) frd("R9 drain", A_DT);
      frd("R5 overflow sticky", A_ST);
      fwr("R5 clear overflow", A_ST, 32'h2);
      frd("R5 overflow cleared", A_ST);

      // R10: simultaneous push and pop on a partly filled log
      hwr("R10 prefill", 13'h0020, 32'h1);
      hwr("R10 prefill", 13'h0024, 32'h2);
      op("R10 push with pop", 1, 0, 13'h0028, 32'h3, 0, 1, A_DT, '0);
      frd("R10 pop", A_DT);
      frd("R10 pop", A_DT);
      frd("R10 empty", A_ST);

      // R2: collision, host wins
      op("R2 collision", 1, 0, 13'h0030, 32'h1111_1111, 1, 0, 13'h0030, 32'h2222_2222);
      frd("R2 host wins", 13'h0030);
      fwr("R2 fw write", 13'h1008, 32'h3333_3333);
      hrd("R2 host sees fw", 13'h1008);
      frd("R2 drain", A_DT);

      // R2: constrained random traffic
      for (int n = 0; n < 1500; n++) begin
         logic [12:0] ha, fa;
         bit hw, hr, fw, fr;
         ha = pick_addr();
         fa = pick_addr();
         hw = ($urandom_range(0, 3) == 0);
         hr = ($urandom_range(0, 2) == 0);
         fw = ($urandom_range(0, 3) == 0);
         fr = !fw && ($urandom_range(0, 1) == 0);
         if ($urandom_range(0, 2) == 0) begin fr = 1'b1; fw = 1'b0; fa = A_DT; end
         op("R2 random", hw, hr, ha, $urandom(), fw, fr, fa, $urandom());
      end
      idle();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule